// File: doc/BRIEF.md
# BCD Digit Serial Formatter

This block sits behind a 4½-digit integrating converter that presents its reading one digit at a time on a shared 4-bit BCD bus. Each digit comes with its own strobe line. On the rising edge of a strobe, the block captures the bus and the status flags and builds one byte. The upper nibble of that byte identifies the digit position and the lower nibble carries the digit value. The block then sends the byte as an asynchronous serial frame. A full reading therefore goes out as five frames, one for each strobe.

The sign of the reading travels in the parity sense of every frame. A positive reading uses even parity and a negative reading uses odd parity, so a receiver fixed to one parity sense can recover the sign from its parity-error flag. When the overlay input is high, the unused upper bits of the half-digit byte carry polarity, over-range and under-range instead.

Top module: `bcd_serial_fmt`

## Requirements
- R1: After reset, tx_o is high, busy_o is low and overrun_o is low. Whenever busy_o is low, tx_o is high.
- R2: Each frame is 11 bits, each held for BAUD_DIV clock cycles. The order is a low start bit, 8 data bits with the LSB first, a parity bit, and a high stop bit. The start bit appears on tx_o in the cycle right after the clock edge that sees the strobe rise.
- R3: The upper nibble (bits 7:4) of each byte codes the position. Strobe index 0 (the half digit) gives 0000, index 1 gives 1000, index 2 gives 0100, index 3 gives 0010 and index 4 gives 0001.
- R4: With overlay off, the lower nibble (bits 3:0) equals bcd_i as captured.
- R5: The parity bit makes the count of ones in data plus parity even when pol_i=1 at capture, and odd when pol_i=0.
- R6: With overlay on, the index 0 byte carries the captured values in its low bits: bit 0 = bcd_i[0], bit 1 = pol_i, bit 2 = ovr_i and bit 3 = und_i. Bytes for indices 1 to 4 are unaffected.
- R7: Inputs are captured on the clock edge where a strobe bit is first seen high. Later changes to bcd_i, pol_i, ovr_i, und_i or ovl_i do not alter the frame in flight.
- R8: busy_o rises on the capture edge and stays high for exactly 11*BAUD_DIV cycles.
- R9: A strobe rising while busy_o is high is ignored and leaves the frame in progress unchanged. It sets overrun_o, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bcd_i | input | 4 | Multiplexed BCD digit bus |
| dstb_i | input | 5 | One-hot digit strobes; bit 0 is the half digit |
| pol_i | input | 1 | Polarity, 1 = positive |
| ovr_i | input | 1 | Over-range flag |
| und_i | input | 1 | Under-range flag |
| ovl_i | input | 1 | Overlay flags onto half-digit byte |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame in progress |
| overrun_o | output | 1 | Sticky strobe-during-frame flag |

## Verification
The assertions take for granted that the strobes are at most one-hot and are synchronous to clk_i. They also assume dstb_i is held low through reset, so the checker's edge detector starts from a known level. The stimulus raises exactly one strobe per digit and drops it on the next cycle. Between strobes it waits until busy_o has fallen, except for one deliberate strobe injected mid-frame to exercise the overrun path. Bus and flag values are scrambled right after each capture, so any late sampling would show up in the decoded byte.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  localparam int NUM_DIG    = 5;
  localparam int FRAME_BITS = 11;
  localparam int IDX_W      = $clog2(NUM_DIG);

  typedef struct packed {
    logic [3:0] bcd;
    logic       pol;
    logic       ovr;
    logic       und;
    logic       ovl;
  } dig_in_t;

  // walking-one position code, half digit is all zero
  function automatic logic [3:0] pos_code(input logic [IDX_W-1:0] idx);
    logic [3:0] c;
    if (idx == '0) c = 4'b0000;
    else           c = 4'b1000 >> (idx - 1'b1);
    return c;
  endfunction
endpackage

// File: rtl/bsf_strobe_edge.sv
module bsf_strobe_edge #(
  parameter int N   = 5,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  stb_i,
  output logic          fire_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] stb_q, rise;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stb_q <= '0;
    else         stb_q <= stb_i;

  assign rise   = stb_i & ~stb_q;
  assign fire_o = |rise;

  // lowest index wins if several rise together
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (rise[i]) idx_o = IW'(i);
  end
endmodule

// File: rtl/bsf_byte_build.sv
module bsf_byte_build
  import bsf_pkg::*;
(
  input  dig_in_t          din_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o,
  output logic             par_o
);
  logic [3:0] lo;

  always_comb begin
    lo = din_i.bcd;
    if (din_i.ovl && idx_i == '0) lo = {din_i.und, din_i.ovr, din_i.pol, din_i.bcd[0]};
  end

  assign byte_o = {pos_code(idx_i), lo};
  // even parity for positive, odd for negative
  assign par_o  = (^byte_o) ^ ~din_i.pol;
endmodule

// File: rtl/bsf_frame_tx.sv
module bsf_frame_tx
  import bsf_pkg::*;
#(
  parameter int BAUD_DIV = 16,
  localparam int CW      = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1,
  localparam int BW      = $clog2(FRAME_BITS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       par_i,
  output logic       tx_o,
  output logic       busy_o
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [CW-1:0]         baud_q;
  logic [BW-1:0]         bit_q;
  logic                  busy_q;
  logic                  tick;

  assign tick = (baud_q == CW'(BAUD_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      baud_q <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= {1'b1, par_i, data_i, 1'b0};
      baud_q <= '0;
      bit_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (tick) begin
        baud_q <= '0;
        if (bit_q == BW'(FRAME_BITS - 1)) begin
          busy_q <= 1'b0;
        end else begin
          sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
          bit_q <= bit_q + 1'b1;
        end
      end else begin
        baud_q <= baud_q + 1'b1;
      end
    end
  end

  assign tx_o   = ~busy_q | sh_q[0];
  assign busy_o = busy_q;
endmodule

// File: rtl/bcd_serial_fmt.sv
module bcd_serial_fmt
  import bsf_pkg::*;
#(
  parameter int BAUD_DIV = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         bcd_i,
  input  logic [NUM_DIG-1:0] dstb_i,
  input  logic               pol_i,
  input  logic               ovr_i,
  input  logic               und_i,
  input  logic               ovl_i,
  output logic               tx_o,
  output logic               busy_o,
  output logic               overrun_o
);
  logic             fire, load, par, busy, ovr_q;
  logic [IDX_W-1:0] idx;
  logic [7:0]       byte_w;
  dig_in_t          din;

  assign din = '{bcd: bcd_i, pol: pol_i, ovr: ovr_i, und: und_i, ovl: ovl_i};

  bsf_strobe_edge #(.N(NUM_DIG)) i_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .stb_i(dstb_i), .fire_o(fire), .idx_o(idx)
  );

  bsf_byte_build i_build (
    .din_i(din), .idx_i(idx), .byte_o(byte_w), .par_o(par)
  );

  assign load = fire & ~busy;

  bsf_frame_tx #(.BAUD_DIV(BAUD_DIV)) i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .data_i(byte_w),
    .par_i(par), .tx_o(tx_o), .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          ovr_q <= 1'b0;
    else if (fire & busy) ovr_q <= 1'b1;

  assign busy_o    = busy;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/bsf_checker.sv
module bsf_checker #(
  parameter int BAUD_DIV = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] dstb_i,
  input logic       tx_o,
  input logic       busy_o,
  input logic       overrun_o
);
  logic [4:0] stb_q;
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      stb_q    <= '0;
      busy_cnt <= 0;
    end else begin
      stb_q    <= dstb_i;
      busy_cnt <= busy_o ? busy_cnt + 1 : 0;
    end

  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tx_o);

  a_r8_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt == 11 * BAUD_DIV);

  a_r9_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && |(dstb_i & ~stb_q)) |=> overrun_o);

  a_r9_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  a_r8_busy_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && |(dstb_i & ~stb_q)) |=> busy_o);
endmodule

bind bcd_serial_fmt bsf_checker #(.BAUD_DIV(BAUD_DIV)) i_bsf_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .dstb_i(dstb_i), .tx_o(tx_o),
  .busy_o(busy_o), .overrun_o(overrun_o)
);

// File: tb/test_bcd_serial_fmt.sv
module test_bcd_serial_fmt;
  localparam int B = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] bcd_i = '0;
  logic [4:0] dstb_i = '0;
  logic       pol_i = 1'b0, ovr_i = 1'b0, und_i = 1'b0, ovl_i = 1'b0;
  logic       tx_o, busy_o, overrun_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  bcd_serial_fmt #(.BAUD_DIV(B)) i_bcd_serial_fmt (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int idx, input logic [3:0] bcd,
      input logic pol, input logic ovr, input logic und, input logic ovl);
    logic [3:0] hi, lo;
    case (idx)
      0: hi = 4'b0000;
      1: hi = 4'b1000;
      2: hi = 4'b0100;
      3: hi = 4'b0010;
      default: hi = 4'b0001;
    endcase
    lo = (ovl && idx == 0) ? {und, ovr, pol, bcd[0]} : bcd;
    return {hi, lo};
  endfunction

  // called at a negedge; returns at the negedge after the frame ends
  task automatic send(input int idx, input logic [3:0] bcd, input logic pol,
      input logic ovr, input logic und, input logic ovl, input bit inject);
    logic [10:0] rx;
    logic [7:0]  eb;
    int          wait_n;
    bcd_i = bcd; pol_i = pol; ovr_i = ovr; und_i = und; ovl_i = ovl;
    dstb_i = 5'b1 << idx;
    @(posedge clk_i);
    @(negedge clk_i);
    dstb_i = '0;
    bcd_i = 4'($urandom); pol_i = 1'($urandom); ovr_i = 1'($urandom);
    und_i = 1'($urandom); ovl_i = 1'($urandom);          // R7 scramble
    repeat (B / 2) @(negedge clk_i);
    for (int j = 0; j < 11; j++) begin
      if (j > 0) repeat (wait_n) @(negedge clk_i);
      wait_n = B;
      rx[j] = tx_o;
      if (j == 5) chk(busy_o === 1'b1, "R8 busy mid frame", busy_o, 1);
      if (inject && j == 3) begin
        dstb_i = 5'b1 << ((idx + 1) % 5);
        @(negedge clk_i);
        dstb_i = '0;
        wait_n = B - 1;
      end
    end
    eb = exp_byte(idx, bcd, pol, ovr, und, ovl);
    chk(rx[0] == 1'b0 && rx[10] == 1'b1, "R2 start/stop", {rx[10], rx[0]}, 2'b10);
    chk(rx[8:5] == eb[7:4], "R3 position code", rx[8:5], eb[7:4]);
    if (ovl && idx == 0)
      chk(rx[4:1] == eb[3:0], "R6 R7 overlay nibble", rx[4:1], eb[3:0]);
    else
      chk(rx[4:1] == eb[3:0], "R4 R7 bcd nibble", rx[4:1], eb[3:0]);
    chk(rx[9] == ((^eb) ^ ~pol), "R5 parity sense", rx[9], (^eb) ^ ~pol);
    repeat (B / 2) @(negedge clk_i);
    chk(busy_o === 1'b0 && tx_o === 1'b1, "R8 busy end", {busy_o, tx_o}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(tx_o === 1'b1 && busy_o === 1'b0 && overrun_o === 1'b0, "R1 reset state",
        {tx_o, busy_o, overrun_o}, 3'b100);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(tx_o === 1'b1 && busy_o === 1'b0, "R1 idle after reset", {tx_o, busy_o}, 2'b10);
    // directed corners
    send(0, 4'b0001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    send(0, 4'b0001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    send(0, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(4, 4'd9, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    send(1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(overrun_o === 1'b0, "R9 no overrun yet", overrun_o, 0);
    send(2, 4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);  // R9 injected strobe
    chk(overrun_o === 1'b1, "R9 overrun set", overrun_o, 1);
    // random readings
    for (int r = 0; r < 40; r++) begin
      logic p, o, u, m;
      p = 1'($urandom); o = 1'($urandom); u = 1'($urandom); m = 1'($urandom);
      for (int d = 0; d < 5; d++) begin
        send(d, (d == 0) ? 4'($urandom % 2) : 4'($urandom % 10), p, o, u, m, 1'b0);
        repeat ($urandom % 4) @(negedge clk_i);
      end
    end
    chk(overrun_o === 1'b1, "R9 overrun sticky", overrun_o, 1);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule